// File: doc/BRIEF.md
# Critical-Mode PFC Cycle Sequencer

This block produces the switch gate of a boost power-factor-correction stage running in critical conduction (boundary) mode. It does not see analog voltages: external comparators hand it single-bit flags, and the block turns those flags into a gate waveform. Each switching period begins when the inductor current is seen to reach zero and ends on the first of three things: the overcurrent flag, the end of the commanded on-time, or a hard maximum on-time.

Around that core loop sit the timers that keep the stage safe. An inhibit window after each turn-off caps the switching frequency. A zero-current event that arrives inside the window is remembered and acted on when the window closes. If no zero-current event comes, a restart timer starts a pulse on its own. A separate disable flag, and the output over- and under-voltage flags, each stop switching once they have stayed asserted for their own debounce time. Switching resumes when they clear. All durations are given in nanoseconds and turned into clock cycles from a clock-frequency parameter. The commanded on-time comes either from a comparator flag or from a cycle count, chosen by a parameter.

Top module: `pfc_cycle_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `pfc_gate` is 0 after that edge.
- R2: The flags `zcd_below`, `oc_trip`, `ton_end`, `zcd_dis_low`, `ov_flag` and `uv_flag` each pass through two synchronizing flops. A 0-to-1 change of `zcd_below` outside the inhibit window turns the gate on at the third rising edge after the change, so the gate is low for exactly d+3 cycles when the change comes d cycles after turn-off and d+3 is at least INH_CYC.
- R3: After every turn-off the gate stays low for at least INH_CYC cycles (INHIBIT_NS of clock time). A zero-current event that falls inside the window is held, and the gate then turns on exactly INH_CYC cycles after turn-off.
- R4: If no zero-current event arrives, the gate turns on exactly RST_CYC cycles (RESTART_NS) after turn-off.
- R5: A 0-to-1 change of `oc_trip` during an on-period ends it at the third rising edge after the change.
- R6: With USE_TON_COUNT = 0, a 0-to-1 change of `ton_end` during an on-period ends it at the third rising edge after the change.
- R7: No on-period lasts more than MAX_ON_CYC cycles (MAX_ON_NS). With no terminating flag, it lasts exactly that long.
- R8: With USE_TON_COUNT = 1, each on-period lasts exactly `ton_cycles` cycles, capped at MAX_ON_CYC, and `ton_end` has no effect.
- R9: `zcd_dis_low` held for DIS_CYC cycles (DIS_DEB_NS) forces the gate low and keeps it low while the flag stays asserted. Once the flag clears, switching resumes through the restart timer.
- R10: `ov_flag` or `uv_flag` held for FLT_CYC cycles (FLT_DEB_NS) forces the gate low until the flag clears. A pulse shorter than FLT_CYC leaves the gate timing unchanged.
- R11: `en` low forces the gate low at the next rising edge and clears every timer and held event. After `en` returns high, the first turn-on happens at the RST_CYC-th rising edge with `en` high, unless a zero-current event comes earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Global enable, synchronous to clk |
| zcd_below | input | 1 | Zero-current detect comparator: 1 when the winding voltage is below the trigger level (asynchronous) |
| oc_trip | input | 1 | Cycle-by-cycle current limit comparator (asynchronous) |
| ton_end | input | 1 | Ramp versus error-voltage compare, on-time reached (asynchronous) |
| zcd_dis_low | input | 1 | Detect pin held near ground, requesting disable (asynchronous) |
| ov_flag | input | 1 | Output over-voltage comparator (asynchronous) |
| uv_flag | input | 1 | Output under-voltage comparator (asynchronous) |
| ton_cycles | input | TON_W | Commanded on-time in cycles, used when USE_TON_COUNT = 1 |
| pfc_gate | output | 1 | Gate command to the driver |

## Verification
The hardest case to reach from the ports is a zero-current edge that lands inside the inhibit window. It must be held rather than dropped, and its effect shows only as a low time equal to INH_CYC instead of RST_CYC. The stimulus reaches it by timing every zero-current edge from the observed gate fall, with random delays that fall on both sides of the window edge, and by comparing each measured low and high time to the bench's own model. The debounced faults are reached by holding a flag past its debounce count and, separately, by pulsing it for less than that count during a restart wait. In the second case the exact restart time proves the pulse had no effect.

// File: rtl/pfc_seq_pkg.sv
// Shared types and helpers for the PFC cycle sequencer.
// Assumes every duration is given in nanoseconds and the clock in Hz.
package pfc_seq_pkg;

    typedef enum logic [1:0] {
        ST_OFF = 2'd0,   // inhibit window after turn-off
        ST_ARM = 2'd1,   // waiting for zero current or restart
        ST_ON  = 2'd2    // gate on
    } seq_state_t;

    // Convert a duration to clock cycles, never fewer than one
    function automatic int cycles_of(input longint hz, input longint ns);
        longint c;
        c = (hz * ns) / 64'd1_000_000_000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/pfc_sync2.sv
// Two-flop synchronizer for a vector of independent asynchronous flags.
// Assumes the flags are level signals; bits are not coherent with each other.
module pfc_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // capture and re-time the asynchronous inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pfc_flag_debounce.sv
// Persistence filter: held goes high once din has been high for N
// consecutive cycles, and drops the cycle after din goes low.
// Assumes din is already synchronous. clr restarts the count.
module pfc_flag_debounce #(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic din,
    output logic held
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic [CW-1:0] cnt;

    // count consecutive asserted cycles, declare the fault at N
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !din) begin
            cnt  <= '0;
            held <= 1'b0;
        end else if (cnt == LAST) begin
            held <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pfc_cycle_seq.sv
// Critical-conduction-mode PFC gate sequencer.
// Turns the gate on at a zero-current edge (held through the inhibit
// window), or on restart time-out, and ends each on-period on the first
// of overcurrent, on-time end, or maximum on-time. Debounced disable,
// over-voltage and under-voltage flags, and a low enable, hold it off.
// Assumes comparator flags are asynchronous and en is synchronous.
module pfc_cycle_seq
    import pfc_seq_pkg::*;
#(
    parameter int CLK_HZ        = 50_000_000,
    parameter int INHIBIT_NS    = 2_500,
    parameter int RESTART_NS    = 500_000,
    parameter int MAX_ON_NS     = 25_000,
    parameter int DIS_DEB_NS    = 150_000,
    parameter int FLT_DEB_NS    = 70_000,
    parameter bit USE_TON_COUNT = 1'b0,
    parameter int TON_W         = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             zcd_below,
    input  logic             oc_trip,
    input  logic             ton_end,
    input  logic             zcd_dis_low,
    input  logic             ov_flag,
    input  logic             uv_flag,
    input  logic [TON_W-1:0] ton_cycles,
    output logic             pfc_gate
);
    localparam int INH_CYC    = cycles_of(CLK_HZ, INHIBIT_NS);
    localparam int RST_CYC    = cycles_of(CLK_HZ, RESTART_NS);
    localparam int MAX_ON_CYC = cycles_of(CLK_HZ, MAX_ON_NS);
    localparam int DIS_CYC    = cycles_of(CLK_HZ, DIS_DEB_NS);
    localparam int FLT_CYC    = cycles_of(CLK_HZ, FLT_DEB_NS);
    localparam int TOP_CYC    = (RST_CYC > MAX_ON_CYC) ? RST_CYC : MAX_ON_CYC;
    localparam int CW         = $clog2(TOP_CYC + 1);
    localparam int NFLT       = 3;

    localparam logic [CW-1:0] INH_LAST = CW'(INH_CYC - 1);
    localparam logic [CW-1:0] RST_LAST = CW'(RST_CYC - 1);
    localparam logic [CW-1:0] ON_LAST  = CW'(MAX_ON_CYC - 1);

    logic [5:0]      raw_flags;
    logic [5:0]      s_flags;
    logic            zs, ocs, tons;
    logic [NFLT-1:0] flt_in;
    logic [NFLT-1:0] flt_held;
    logic            fault_hold;
    logic            run_ok;
    logic            zcd_prev;
    logic            zcd_edge;
    logic            ton_done;
    logic            pend;
    logic [CW-1:0]   cnt;
    seq_state_t      st;

    assign raw_flags = {uv_flag, ov_flag, zcd_dis_low, ton_end, oc_trip, zcd_below};

    pfc_sync2 #(.W(6)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_flags),
        .q    (s_flags)
    );

    assign zs     = s_flags[0];
    assign ocs    = s_flags[1];
    assign tons   = s_flags[2];
    assign flt_in = s_flags[5:3];

    // one persistence filter per hold-off source; index 0 is the disable request
    for (genvar i = 0; i < NFLT; i++) begin : g_deb
        pfc_flag_debounce #(.N((i == 0) ? DIS_CYC : FLT_CYC)) u_deb (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (!en),
            .din  (flt_in[i]),
            .held (flt_held[i])
        );
    end

    assign fault_hold = |flt_held;
    assign run_ok     = en && !fault_hold;
    assign zcd_edge   = zs && !zcd_prev;

    // on-time source: comparator flag, or elapsed count against the command
    assign ton_done = USE_TON_COUNT
                    ? ((32'(cnt) + 32'd1) >= 32'(ton_cycles))
                    : tons;

    // switching-cycle state machine with shared period counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_OFF;
            cnt      <= '0;
            pend     <= 1'b0;
            zcd_prev <= 1'b0;
        end else begin
            zcd_prev <= zs;
            if (!run_ok) begin
                st   <= ST_OFF;
                cnt  <= '0;
                pend <= 1'b0;
            end else begin
                unique case (st)
                    ST_OFF: begin
                        cnt <= cnt + 1'b1;
                        if (zcd_edge) pend <= 1'b1;
                        if (cnt == INH_LAST) begin
                            if (pend || zcd_edge) begin
                                st   <= ST_ON;
                                cnt  <= '0;
                                pend <= 1'b0;
                            end else begin
                                st <= ST_ARM;
                            end
                        end
                    end
                    ST_ARM: begin
                        cnt <= cnt + 1'b1;
                        if (zcd_edge || cnt == RST_LAST) begin
                            st  <= ST_ON;
                            cnt <= '0;
                        end
                    end
                    ST_ON: begin
                        cnt <= cnt + 1'b1;
                        if (ocs || ton_done || cnt == ON_LAST) begin
                            st  <= ST_OFF;
                            cnt <= '0;
                        end
                    end
                    default: begin
                        st  <= ST_OFF;
                        cnt <= '0;
                    end
                endcase
            end
        end
    end

    assign pfc_gate = (st == ST_ON);

endmodule

// File: rtl/pfc_seq_checker.sv
// Timing properties of the PFC sequencer, bound to every instance.
// Keeps its own run-length counters of the gate.
module pfc_seq_checker #(
    parameter int INH_CYC    = 1,
    parameter int MAX_ON_CYC = 1
) (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic hold,
    input logic gate
);
    logic [31:0] lo_run;
    logic [31:0] hi_run;

    // track how long the gate has been in its current level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_run <= '0;
            hi_run <= '0;
        end else begin
            lo_run <= gate ? 32'd0 : lo_run + 32'd1;
            hi_run <= gate ? hi_run + 32'd1 : 32'd0;
        end
    end

    // R3: every low interval lasts at least the inhibit window
    p_min_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> lo_run >= 32'(INH_CYC));

    // R7: no on-period exceeds the maximum on-time
    p_max_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> hi_run < 32'(MAX_ON_CYC));

    // R9 and R10: a debounced hold-off source forces the gate low next cycle
    p_fault_forces_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !gate);

    // R11: enable low forces the gate low at the next edge
    p_disable_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !gate);

    // R11: a turn-on is only ever preceded by an enabled cycle
    p_rise_needs_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> $past(en));

endmodule

bind pfc_cycle_seq pfc_seq_checker #(
    .INH_CYC   (INH_CYC),
    .MAX_ON_CYC(MAX_ON_CYC)
) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en),
    .hold (fault_hold),
    .gate (pfc_gate)
);

// File: tb/pfc_cycle_seq_test.sv
// Self-checking bench: directed corner cases plus seeded random cycles.
module pfc_cycle_seq_test;
    localparam int HZ = 2_000_000;

    function automatic int cyc(input longint ns);
        longint c;
        c = (HZ * ns) / 1_000_000_000;
        return (c < 1) ? 1 : int'(c);
    endfunction

    localparam int INH  = cyc(2_500);
    localparam int RST  = cyc(500_000);
    localparam int MXON = cyc(25_000);
    localparam int DIS  = cyc(150_000);
    localparam int FLT  = cyc(70_000);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic zcd = 1'b0, oc = 1'b0, ton = 1'b0, dis = 1'b0, ov = 1'b0, uv = 1'b0;
    logic [15:0] ton_cyc2 = 16'd7;
    logic gate, gate2;
    int n_run = 0, n_fail = 0, ncyc = 0;

    always #10 clk = ~clk;

    pfc_cycle_seq #(.CLK_HZ(HZ)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .zcd_below(zcd), .oc_trip(oc),
        .ton_end(ton), .zcd_dis_low(dis), .ov_flag(ov), .uv_flag(uv),
        .ton_cycles(16'd0), .pfc_gate(gate)
    );

    pfc_cycle_seq #(.CLK_HZ(HZ), .USE_TON_COUNT(1'b1)) uut_cnt (
        .clk(clk), .rst_n(rst_n), .en(en), .zcd_below(1'b0), .oc_trip(1'b0),
        .ton_end(1'b1), .zcd_dis_low(1'b0), .ov_flag(1'b0), .uv_flag(1'b0),
        .ton_cycles(ton_cyc2), .pfc_gate(gate2)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_hi(input int t);
        return (t + 3 < MXON) ? t + 3 : MXON;
    endfunction

    function automatic int exp_lo(input int d);
        if (d < 0) return RST;
        return (d + 3 > INH) ? d + 3 : INH;
    endfunction

    task automatic wait_rise(input int limit, output int n);
        n = 0;
        while (!gate && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    // called at the first high sample; returns high and low run lengths
    task automatic run_cycle(input int t, input int d, input bit use_oc,
                             input int glitch, output int hi, output int lo);
        int k = 0;
        int j = 0;
        hi = 1;
        zcd = 1'b0;
        if (t == 0) begin if (use_oc) oc = 1'b1; else ton = 1'b1; end
        forever begin
            @(negedge clk);
            k++;
            if (!gate || k > 5000) break;
            hi++;
            if (k == t) begin if (use_oc) oc = 1'b1; else ton = 1'b1; end
        end
        oc = 1'b0;
        ton = 1'b0;
        lo = 1;
        if (d == 0) zcd = 1'b1;
        if (glitch > 0) ov = 1'b1;
        forever begin
            @(negedge clk);
            j++;
            if (gate || j > 5000) break;
            lo++;
            if (j == d) zcd = 1'b1;
            if (glitch > 0 && j == glitch) ov = 1'b0;
        end
    endtask

    task automatic hold_fault(input int which, input int settle, input string req);
        int highs = 0;
        int n;
        if (which == 0) dis = 1'b1; else if (which == 1) ov = 1'b1; else uv = 1'b1;
        zcd = 1'b0;
        repeat (settle) @(negedge clk);
        for (int i = 0; i < RST + 200; i++) begin
            @(negedge clk);
            if (gate) highs++;
        end
        check(highs == 0, {req, " held flag keeps gate low"}, highs, 0);
        dis = 1'b0; ov = 1'b0; uv = 1'b0;
        wait_rise(RST + 20, n);
        check(gate == 1'b1, {req, " switching resumes after clear"}, int'(gate), 1);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            ncyc++;
            if (ncyc > 150_000) begin
                n_fail++;
                n_run++;
                $display("FAIL watchdog: actual %0d expected below %0d", ncyc, 150_000);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin : stim
        int hi, lo, n, t, d;
        bit use_oc;
        void'($urandom(32'd12345));
        repeat (4) @(negedge clk);
        check(gate == 1'b0 && gate2 == 1'b0, "R1 gate low in reset", int'(gate | gate2), 0);
        rst_n = 1'b1;
        en = 1'b1;

        // R8: count mode on-time, ton_end tied high is ignored
        n = 0;
        while (!gate2 && n < 3000) begin @(negedge clk); n++; end
        hi = 0;
        while (gate2 && hi < 3000) begin @(negedge clk); hi++; end
        check(hi == 7, "R8 count-mode on-time", hi, 7);
        ton_cyc2 = 16'd200;
        while (!gate2 && n < 6000) begin @(negedge clk); n++; end
        hi = 0;
        while (gate2 && hi < 3000) begin @(negedge clk); hi++; end
        check(hi == MXON, "R8 count-mode capped at maximum", hi, MXON);

        wait_rise(3000, n);
        run_cycle(0, 0, 1'b0, 0, hi, lo);
        check(hi == 3, "R6 on-time flag latency", hi, 3);
        check(lo == INH, "R3 edge in inhibit is held", lo, INH);
        run_cycle(60, 10, 1'b0, 0, hi, lo);
        check(hi == MXON, "R7 maximum on-time", hi, MXON);
        check(lo == 13, "R2 zero-current turn-on latency", lo, 13);
        run_cycle(4, 2, 1'b1, 0, hi, lo);
        check(hi == 7, "R5 overcurrent ends on-period", hi, 7);
        check(lo == INH, "R3 edge at window end", lo, INH);
        run_cycle(5, -1, 1'b0, 0, hi, lo);
        check(lo == RST, "R4 restart without zero current", lo, RST);
        run_cycle(5, -1, 1'b0, FLT / 2, hi, lo);
        check(lo == RST, "R10 short fault pulse has no effect", lo, RST);

        for (int i = 0; i < 30; i++) begin
            t = int'($urandom % 70);
            d = int'($urandom % 40);
            use_oc = 1'(($urandom >> 4) & 1);
            run_cycle(t, d, use_oc, 0, hi, lo);
            check(hi == exp_hi(t), use_oc ? "R5 random on" : "R6 random on", hi, exp_hi(t));
            check(lo == exp_lo(d), "R2 random off", lo, exp_lo(d));
        end

        hold_fault(0, DIS + 20, "R9");
        hold_fault(1, FLT + 20, "R10 over-voltage");
        hold_fault(2, FLT + 20, "R10 under-voltage");

        // R11: enable drop and timer restart
        en = 1'b0;
        @(negedge clk);
        check(gate == 1'b0, "R11 gate low after enable drop", int'(gate), 0);
        repeat (20) @(negedge clk);
        en = 1'b1;
        n = 0;
        forever begin
            @(negedge clk);
            if (gate || n > 3000) break;
            n++;
        end
        check(n == RST - 1, "R11 first turn-on after re-enable", n, RST - 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule